// File: doc/BRIEF.md
# Monochrome Planar Pixel Mapper

This block sits between the planar graphics fetch and the digital colour output of an 8-colour graphics pipeline. On every cycle with the pixel strobe high, it takes one bit from each of three colour planes. Plane G gives the most significant index bit, then R, then B. It looks the 3-bit index up in a programmable 8-entry digital palette and drives a 3-bit digital colour one clock later. When 16-colour analog mode is selected, a fourth plane, E, is also presented.

An optional monochrome mode reduces each remapped colour to black or white. The decision uses bit 2 of the palette output, so software picks which indices light up by reprogramming the palette. When 16-colour mode is also active, a lit pixel is additionally blanked wherever the E plane is set. The analog palette plays no part in this block.

Software programs the palette and the mode through a small write-only register port. A write in the same cycle as a pixel never affects that pixel.

Top module: `planar_mono_mapper`

## Requirements
- R1: After reset the palette is identity (entry n holds n), monochrome is off, `rgb_valid` is 0 and `rgb_out` is 0.
- R2: The pixel index is {plane_g, plane_r, plane_b}, so plane_g is bit 2. With monochrome off, `rgb_out` equals the palette entry at that index in the cycle after `pix_valid`.
- R3: A write to address k (0 to 3) sets entry 2k from wdata[6:4] and entry 2k+1 from wdata[2:0]. wdata bits 7 and 3 are ignored.
- R4: A write to address 4 with value 8'h02 turns monochrome off, and 8'h03 turns it on. Any other value leaves the mode unchanged.
- R5: With monochrome on and `sel16` low, `rgb_out` is 3'b111 when bit 2 of the palette entry is 1, and 3'b000 otherwise.
- R6: With monochrome on and `sel16` high, `rgb_out` is 3'b111 only when bit 2 of the palette entry is 1 and plane_e is 0; otherwise it is 3'b000.
- R7: With monochrome off, `plane_e` and `sel16` have no effect on `rgb_out`.
- R8: A register write in the same cycle as `pix_valid` does not affect that pixel; the pixel uses the settings held before the write.
- R9: `rgb_valid` is `pix_valid` delayed by one cycle. `rgb_out` holds its value in any cycle that follows a cycle without a pixel.
- R10: Writes to addresses 5 to 7 change neither the palette nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Plane bits carry a pixel this cycle |
| plane_g | input | 1 | G plane bit, index MSB |
| plane_r | input | 1 | R plane bit, index middle bit |
| plane_b | input | 1 | B plane bit, index LSB |
| plane_e | input | 1 | E plane bit, used only in 16-colour mode |
| sel16 | input | 1 | 16-colour analog mode is selected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 to 3 palette pairs, 4 mode |
| reg_wdata | input | 8 | Register write data |
| rgb_valid | output | 1 | `rgb_out` carries a new pixel |
| rgb_out | output | 3 | Digital colour {G,R,B} |

## Verification
The hardest case to reach from the ports is a register write that lands in the same cycle as a pixel. That pixel must use the old palette or mode, and the next pixel must use the new one. The bench drives both strobes on one edge, for a palette entry and separately for a mode toggle. It then checks the pixel in flight and the following pixel against its own model. All remaining behaviour is covered by sweeping 32 arithmetically generated palettes, which cover every entry value in every position. Each palette is crossed with both modes, both `sel16` values and all 16 plane combinations.

// File: rtl/pmm_pkg.sv
// Package: shared constants and types for the monochrome planar pixel mapper.
// Assumes a 3-bit digital colour, G as the most significant bit.
package pmm_pkg;
    localparam int COLOR_W = 3;
    localparam int ENTRIES = 1 << COLOR_W;
    localparam logic [7:0] MODE_MONO_OFF = 8'h02;
    localparam logic [7:0] MODE_MONO_ON  = 8'h03;

    typedef logic [COLOR_W-1:0] color_t;

    // Plane bits of one pixel
    typedef struct packed {
        logic g;
        logic r;
        logic b;
        logic e;
    } planes_t;
endpackage

// File: rtl/pmm_palette_regs.sv
// Module: palette and mode register bank.
// Each pair register holds two palette entries: the even entry in the upper
// half of the data byte, the odd entry in the lower half. One further
// address is a mode port that accepts only the two mode codes.
// Assumes DATA_W >= 2*COLOR_W and writes take effect at the clock edge.
module pmm_palette_regs
    import pmm_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int MODE_ADDR = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [ENTRIES*COLOR_W-1:0] pal_flat,
    output logic                       mono_on
);
    localparam int PAIRS  = ENTRIES / 2;
    localparam int HI_LSB = DATA_W / 2;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        color_t even_q, odd_q;

        // Hold one entry pair; reset to identity
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                even_q <= COLOR_W'(2 * k);
                odd_q  <= COLOR_W'(2 * k + 1);
            end else if (wr && addr == ADDR_W'(k)) begin
                even_q <= wdata[HI_LSB +: COLOR_W];
                odd_q  <= wdata[0 +: COLOR_W];
            end
        end

        assign pal_flat[(2*k)*COLOR_W   +: COLOR_W] = even_q;
        assign pal_flat[(2*k+1)*COLOR_W +: COLOR_W] = odd_q;
    end

    // Mode flag: only the two exact codes change it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mono_on <= 1'b0;
        end else if (wr && addr == ADDR_W'(MODE_ADDR)) begin
            if (wdata == DATA_W'(MODE_MONO_ON))
                mono_on <= 1'b1;
            else if (wdata == DATA_W'(MODE_MONO_OFF))
                mono_on <= 1'b0;
        end
    end
endmodule

// File: rtl/pmm_lookup.sv
// Module: combinational palette lookup.
// Selects the entry addressed by the pixel index from the flattened palette.
module pmm_lookup
    import pmm_pkg::*;
(
    input  color_t                     idx,
    input  logic [ENTRIES*COLOR_W-1:0] pal_flat,
    output color_t                     mapped
);
    // Index into the flat entry vector
    always_comb begin
        mapped = pal_flat[idx*COLOR_W +: COLOR_W];
    end
endmodule

// File: rtl/pmm_mono_reduce.sv
// Module: monochrome reduction.
// Passes the remapped colour through when monochrome is off. Otherwise it
// emits all-ones or all-zeros from the top bit of the remapped colour.
// In 16-colour mode a set E plane additionally forces black.
module pmm_mono_reduce
    import pmm_pkg::*;
(
    input  color_t mapped,
    input  logic   plane_e,
    input  logic   sel16,
    input  logic   mono_on,
    output color_t color
);
    logic lit;

    // Decide the final colour for one pixel
    always_comb begin
        lit = mapped[COLOR_W-1] & ~(sel16 & plane_e);
        if (mono_on)
            color = lit ? {COLOR_W{1'b1}} : '0;
        else
            color = mapped;
    end
endmodule

// File: rtl/planar_mono_mapper.sv
// Module: top of the monochrome planar pixel mapper.
// Forms the index from the G, R and B planes, looks it up in the palette,
// optionally reduces to black/white, and registers the result one cycle
// after pix_valid. Registers are read before any same-cycle write lands,
// so a write never alters the pixel in flight.
module planar_mono_mapper
    import pmm_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int MODE_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              plane_g,
    input  logic              plane_r,
    input  logic              plane_b,
    input  logic              plane_e,
    input  logic              sel16,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              rgb_valid,
    output logic [2:0]        rgb_out
);
    logic [ENTRIES*COLOR_W-1:0] pal_flat;
    logic                       mono_on;
    planes_t                    px;
    color_t                     mapped;
    color_t                     color;

    assign px = '{g: plane_g, r: plane_r, b: plane_b, e: plane_e};

    pmm_palette_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MODE_ADDR(MODE_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pal_flat(pal_flat),
        .mono_on (mono_on)
    );

    pmm_lookup u_lookup (
        .idx     ({px.g, px.r, px.b}),
        .pal_flat(pal_flat),
        .mapped  (mapped)
    );

    pmm_mono_reduce u_reduce (
        .mapped (mapped),
        .plane_e(px.e),
        .sel16  (sel16),
        .mono_on(mono_on),
        .color  (color)
    );

    // Output stage: capture colour on a pixel, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_valid <= 1'b0;
            rgb_out   <= '0;
        end else begin
            rgb_valid <= pix_valid;
            if (pix_valid)
                rgb_out <= color;
        end
    end
endmodule

// File: rtl/pmm_checker.sv
// Module: assertion checker bound to planar_mono_mapper.
// Relates the pixel strobe, the mode flag and the output stage over time.
module pmm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_valid,
    input logic       plane_e,
    input logic       sel16,
    input logic       mono_on,
    input logic       rgb_valid,
    input logic [2:0] rgb_out
);
    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> rgb_valid);

    p_no_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!rgb_valid && $stable(rgb_out)));

    p_mono_bw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && mono_on) |=> (rgb_out == 3'b000 || rgb_out == 3'b111));

    p_e_blanks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && mono_on && sel16 && plane_e) |=> (rgb_out == 3'b000));
endmodule

bind planar_mono_mapper pmm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_valid(pix_valid),
    .plane_e  (plane_e),
    .sel16    (sel16),
    .mono_on  (mono_on),
    .rgb_valid(rgb_valid),
    .rgb_out  (rgb_out)
);

// File: tb/planar_mono_mapper_tb.sv
`timescale 1ns/1ps
module planar_mono_mapper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic       plane_g = 1'b0, plane_r = 1'b0, plane_b = 1'b0, plane_e = 1'b0;
    logic       sel16 = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       rgb_valid;
    logic [2:0] rgb_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0] pal_m [8];
    logic       mono_m;

    always #2.5 clk = ~clk;

    planar_mono_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
        .plane_g(plane_g), .plane_r(plane_r), .plane_b(plane_b),
        .plane_e(plane_e), .sel16(sel16), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rgb_valid(rgb_valid), .rgb_out(rgb_out)
    );

    function automatic logic [2:0] expect_rgb(logic [2:0] idx, logic e,
                                              logic s16, logic mono);
        logic [2:0] m;
        m = pal_m[idx];
        if (!mono) return m;
        if (s16) return (m[2] && !e) ? 3'b111 : 3'b000;
        return m[2] ? 3'b111 : 3'b000;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [2:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic load_palette();
        for (int k = 0; k < 4; k++)
            write_reg(3'(k), {1'b1, pal_m[2*k], 1'b1, pal_m[2*k+1]}); // R3 junk bits 7,3
    endtask

    // Drive one pixel, check result the following cycle
    task automatic pixel(string req, logic [2:0] idx, logic e, logic s16);
        pix_valid = 1'b1;
        {plane_g, plane_r, plane_b} = idx;
        plane_e = e; sel16 = s16;
        @(negedge clk);
        pix_valid = 1'b0;
        check(req, {rgb_valid, rgb_out}, {1'b1, expect_rgb(idx, e, s16, mono_m)});
    endtask

    task automatic sweep(string req);
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 16; p++)
                pixel(req, 3'(p >> 1), p[0], s[0]);
    endtask

    initial begin
        for (int n = 0; n < 8; n++) pal_m[n] = 3'(n);
        mono_m = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset outputs
        check("R1", {rgb_valid, rgb_out}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {rgb_valid, rgb_out}, 4'h0);
        // R1/R2: identity palette after reset, G is MSB
        for (int i = 0; i < 8; i++) pixel("R1_R2", 3'(i), 1'b0, 1'b0);
        // R9: no pixel -> valid low, output held
        begin
            logic [2:0] last;
            last = rgb_out;
            @(negedge clk);
            check("R9", {rgb_valid, rgb_out}, {1'b0, last});
        end

        // Main sweep: 32 palettes x mode x sel16 x planes (R2,R3,R5,R6,R7)
        for (int a = 1; a < 8; a += 2) begin
            for (int c = 0; c < 8; c++) begin
                for (int n = 0; n < 8; n++) pal_m[n] = 3'(n * a + c);
                load_palette();
                write_reg(3'd4, 8'h02); mono_m = 1'b0;
                sweep("R2_R3_R7");
                write_reg(3'd4, 8'h03); mono_m = 1'b1;
                sweep("R5_R6");
            end
        end

        // R4: other mode values do nothing (mono currently on)
        write_reg(3'd4, 8'h00);
        write_reg(3'd4, 8'h07);
        write_reg(3'd4, 8'h83);
        sweep("R4");
        write_reg(3'd4, 8'h02); mono_m = 1'b0;
        write_reg(3'd4, 8'h01);
        write_reg(3'd4, 8'h12);
        sweep("R4");

        // R10: writes to 5..7 ignored
        for (int k = 5; k < 8; k++) write_reg(3'(k), 8'h03);
        for (int k = 5; k < 8; k++) write_reg(3'(k), 8'h00);
        sweep("R10");

        // R8: palette write coinciding with a pixel
        pix_valid = 1'b1; {plane_g, plane_r, plane_b} = 3'd0; plane_e = 0; sel16 = 0;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = {1'b0, ~pal_m[0], 1'b0, pal_m[1]};
        @(negedge clk);
        reg_wr = 1'b0; pix_valid = 1'b0;
        check("R8", {rgb_valid, rgb_out}, {1'b1, pal_m[0]});
        pal_m[0] = ~pal_m[0];
        pixel("R8", 3'd0, 1'b0, 1'b0);

        // R8: mode write coinciding with a pixel
        pix_valid = 1'b1; {plane_g, plane_r, plane_b} = 3'd0;
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h03;
        @(negedge clk);
        reg_wr = 1'b0; pix_valid = 1'b0;
        check("R8", {rgb_valid, rgb_out}, {1'b1, expect_rgb(3'd0, 1'b0, 1'b0, 1'b0)});
        mono_m = 1'b1;
        pixel("R8", 3'd0, 1'b0, 1'b0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule